// File: doc/BRIEF.md
# Processor Mode and Status Register Unit

This unit keeps the eight processor flag bits and a separate emulation-mode bit for a CPU core that runs in an 8-bit compatible mode and also has a 16-bit native mode. The decode stage pulses a one-cycle operation strobe with an operation code and an 8-bit immediate. The unit then applies one of four operations on the next clock edge:
- swap the carry bit with the emulation bit;
- OR the immediate into the flags;
- clear the flags selected by the immediate;
- load the flags from the flag-update path.

The datapath reads two width selects from the unit, one for the accumulator and memory accesses and one for the index registers. It also reads a one-cycle strobe that zeroes the upper bytes of both index registers when the index width falls back to 8 bits. All pins are plain control and status signals. The operation strobe has no back-pressure: the unit takes an operation in every cycle in which the strobe is high.

Top module: `pmode_status_unit`

## Requirements
- R1: While reset is active and after it is released, `emu` is 1, `status` is 8'h34 (M, X and I set, all other bits clear), both width outputs are 0 and `idx_hi_clr` is 0.
- R2: The operation code 2'b00 swaps the two bits in one step: `emu` takes the old value of status bit 0 (the carry bit), and status bit 0 takes the old `emu`.
- R3: The status bits, from bit 7 down to bit 0, are N, V, M, X, D, I, Z, C. `acc_wide` is 1 exactly when bit 5 (M) is 0, and `idx_wide` is 1 exactly when bit 4 (X) is 0. The two widths are independent.
- R4: While `emu` is 1, bits 5 and 4 read 1 and both width outputs are 0, whatever operations are applied. Any operation that leaves `emu` at 1 also leaves these two bits at 1.
- R5: The operation code 2'b01 ORs `op_imm` into `status`. The data registers are not touched.
- R6: The operation code 2'b10 clears every status bit where `op_imm` holds a 1, subject to R4.
- R7: The operation code 2'b11 loads `op_imm` into `status`, subject to R4.
- R8: In a cycle without `op_valid`, `status` and `emu` keep their values.
- R9: `idx_hi_clr` is 1 for exactly one cycle: the first cycle in which bit 4 reads 1 after having been 0.
- R10: An operation strobed in cycle k shows on `status`, `emu` and the width outputs from cycle k+1. The width outputs follow the register with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, one operation per high cycle |
| op_code | input | 2 | 00 swap carry/emulation, 01 set bits, 10 clear bits, 11 load |
| op_imm | input | 8 | Immediate mask, or load value |
| status | output | 8 | Current flags N V M X D I Z C |
| emu | output | 1 | Emulation-mode bit |
| acc_wide | output | 1 | 1 selects a 16-bit accumulator and 16-bit memory accesses |
| idx_wide | output | 1 | 1 selects 16-bit index registers |
| idx_hi_clr | output | 1 | One-cycle strobe that zeroes the index high bytes |

## Verification
The assertions check on every cycle that the widths stay 8-bit in emulation mode and that idle cycles hold the state. They also check the exchange, set and clear operations against the previous cycle's operands, and that the clear strobe appears with every rise of X and lasts only one cycle. Only the bench scenarios can show some things: the exact reset value, mixed widths in native mode, and a load's full result. The same goes for long chains of mode changes that interleave with masked operations, which the bench compares against its own model on every cycle.

// File: rtl/pmsr_pkg.sv
package pmsr_pkg;
  localparam int STATUS_W = 8;
  localparam int C_BIT    = 0;
  localparam int X_BIT    = 4;
  localparam int M_BIT    = 5;
  localparam logic [STATUS_W-1:0] STATUS_RST = 8'h34;

  typedef enum logic [1:0] {
    OP_XCHG  = 2'b00,
    OP_SETM  = 2'b01,
    OP_CLRM  = 2'b10,
    OP_LOAD  = 2'b11
  } pmsr_op_e;
endpackage

// File: rtl/pmsr_next.sv
module pmsr_next
  import pmsr_pkg::*;
#(
  parameter int W = STATUS_W
) (
  input  logic         valid,
  input  pmsr_op_e     op,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] cur_p,
  input  logic         cur_emu,
  output logic [W-1:0] nxt_p,
  output logic         nxt_emu
);
  // Emulation bit only changes on an exchange
  assign nxt_emu = (valid && op == OP_XCHG) ? cur_p[C_BIT] : cur_emu;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic raw;
    always_comb begin
      unique case (op)
        OP_XCHG: raw = (b == C_BIT) ? cur_emu : cur_p[b];
        OP_SETM: raw = cur_p[b] | imm[b];
        OP_CLRM: raw = cur_p[b] & ~imm[b];
        default: raw = imm[b];
      endcase
    end
    if (b == M_BIT || b == X_BIT) begin : g_pinned
      // width bits pinned to 1 whenever the resulting mode is emulation
      assign nxt_p[b] = valid ? (raw | nxt_emu) : cur_p[b];
    end else begin : g_free
      assign nxt_p[b] = valid ? raw : cur_p[b];
    end
  end
endmodule

// File: rtl/pmsr_state.sv
module pmsr_state
  import pmsr_pkg::*;
#(
  parameter int W = STATUS_W,
  parameter logic [W-1:0] RST_VAL = STATUS_RST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] nxt_p,
  input  logic         nxt_emu,
  output logic [W-1:0] cur_p,
  output logic         cur_emu,
  output logic         hi_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_p   <= RST_VAL;
      cur_emu <= 1'b1;
      hi_clr  <= 1'b0;
    end else begin
      cur_p   <= nxt_p;
      cur_emu <= nxt_emu;
      hi_clr  <= nxt_p[X_BIT] & ~cur_p[X_BIT];
    end
  end
endmodule

// File: rtl/pmsr_width.sv
module pmsr_width
  import pmsr_pkg::*;
#(
  parameter int W = STATUS_W
) (
  input  logic [W-1:0] cur_p,
  input  logic         cur_emu,
  output logic         acc_wide,
  output logic         idx_wide
);
  assign acc_wide = ~cur_p[M_BIT] & ~cur_emu;
  assign idx_wide = ~cur_p[X_BIT] & ~cur_emu;
endmodule

// File: rtl/pmode_status_unit.sv
module pmode_status_unit
  import pmsr_pkg::*;
#(
  parameter int W = STATUS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [1:0]   op_code,
  input  logic [W-1:0] op_imm,
  output logic [W-1:0] status,
  output logic         emu,
  output logic         acc_wide,
  output logic         idx_wide,
  output logic         idx_hi_clr
);
  logic [W-1:0] nxt_p;
  logic         nxt_emu;
  pmsr_op_e     op;

  assign op = pmsr_op_e'(op_code);

  pmsr_next #(.W(W)) u_next (
    .valid(op_valid), .op(op), .imm(op_imm),
    .cur_p(status), .cur_emu(emu),
    .nxt_p(nxt_p), .nxt_emu(nxt_emu)
  );

  pmsr_state #(.W(W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .nxt_p(nxt_p), .nxt_emu(nxt_emu),
    .cur_p(status), .cur_emu(emu), .hi_clr(idx_hi_clr)
  );

  pmsr_width #(.W(W)) u_width (
    .cur_p(status), .cur_emu(emu),
    .acc_wide(acc_wide), .idx_wide(idx_wide)
  );
endmodule

// File: rtl/pmsr_checker.sv
module pmsr_checker
  import pmsr_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_code,
  input logic [7:0] op_imm,
  input logic [7:0] status,
  input logic       emu,
  input logic       acc_wide,
  input logic       idx_wide,
  input logic       idx_hi_clr
);
  p_reset_emu_r1: assert property (@(posedge clk)
    !rst_n |=> (emu && status[M_BIT] && status[X_BIT] && !idx_hi_clr));

  p_xchg_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b00) |=>
      (emu == $past(status[C_BIT]) && status[C_BIT] == $past(emu)));

  p_emu_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emu |-> (!acc_wide && !idx_wide && status[M_BIT] && status[X_BIT]));

  p_set_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b01) |=> ((status & $past(op_imm)) == $past(op_imm)));

  p_clr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b10) |=> ((status & $past(op_imm) & 8'hCF) == 8'h00));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(status) && $stable(emu)));

  p_clr_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[X_BIT]) |-> idx_hi_clr);

  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_hi_clr |=> !idx_hi_clr);
endmodule

bind pmode_status_unit pmsr_checker u_pmsr_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_imm(op_imm), .status(status), .emu(emu), .acc_wide(acc_wide),
  .idx_wide(idx_wide), .idx_hi_clr(idx_hi_clr)
);

// File: tb/pmode_status_unit_bench.sv
module pmode_status_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [7:0] op_imm = 8'h00;
  logic [7:0] status;
  logic       emu, acc_wide, idx_wide, idx_hi_clr;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m_p;
  logic       m_emu;
  logic       m_clr;

  always #2 clk = ~clk;

  pmode_status_unit u_pmode_status_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_imm(op_imm), .status(status), .emu(emu), .acc_wide(acc_wide),
    .idx_wide(idx_wide), .idx_hi_clr(idx_hi_clr)
  );

  function automatic logic [8:0] ref_next(input logic [7:0] p, input logic e,
                                          input logic v, input logic [1:0] c,
                                          input logic [7:0] m);
    logic [7:0] np;
    logic       ne;
    np = p; ne = e;
    if (v) begin
      case (c)
        2'b00: begin ne = p[0]; np[0] = e; end
        2'b01: np = p | m;
        2'b10: np = p & ~m;
        default: np = m;
      endcase
      if (ne) np[5:4] = 2'b11;
    end
    return {ne, np};
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [11:0] a, x;
    a = {status, emu, acc_wide, idx_wide, idx_hi_clr};
    x = {m_p, m_emu, ~m_p[5] & ~m_emu, ~m_p[4] & ~m_emu, m_clr};
    check(a == x, tag, {4'h0, a}, {4'h0, x});
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [7:0] m,
                      input string tag);
    logic [8:0] r;
    op_valid = v; op_code = c; op_imm = m;
    r = ref_next(m_p, m_emu, v, c, m);
    @(posedge clk);
    m_clr = r[4] & ~m_p[4];
    m_p = r[7:0]; m_emu = r[8];
    @(negedge clk);
    op_valid = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    m_p = 8'h34; m_emu = 1'b1; m_clr = 1'b0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after release");
    // R4: in emulation, clearing widths has no effect
    step(1'b1, 2'b10, 8'h30, "R4 clear widths in emulation");
    step(1'b1, 2'b11, 8'h00, "R7 R4 load zero in emulation");
    // R2: enter native (carry is 0)
    step(1'b1, 2'b00, 8'h00, "R2 exchange into native");
    check(m_p[0] == 1'b1 && !emu, "R2 old emu in carry", {15'h0, status[0]}, 16'h1);
    step(1'b1, 2'b10, 8'h20, "R3 R6 16-bit accumulator only");
    check(acc_wide && !idx_wide, "R3 mixed widths", {14'h0, acc_wide, idx_wide}, 16'h2);
    step(1'b1, 2'b10, 8'h10, "R6 16-bit index");
    step(1'b0, 2'b01, 8'hFF, "R8 idle ignores operands");
    step(1'b1, 2'b01, 8'h10, "R9 index back to 8-bit");
    check(idx_hi_clr, "R9 strobe", {15'h0, idx_hi_clr}, 16'h1);
    step(1'b0, 2'b00, 8'h00, "R9 strobe single cycle");
    step(1'b1, 2'b01, 8'hC2, "R5 set N V Z");
    step(1'b1, 2'b10, 8'h82, "R6 clear N Z");
    step(1'b1, 2'b11, 8'h01, "R7 load with carry set");
    step(1'b1, 2'b00, 8'h00, "R2 R4 exchange into emulation");
    check(emu && status[5:4] == 2'b11, "R4 widths forced", {8'h0, status}, {8'h0, m_p});
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[3:2], r[11:4], "R10 random operation");
    end
    rst_n = 1'b0;
    m_p = 8'h34; m_emu = 1'b1; m_clr = 1'b0;
    @(negedge clk); @(negedge clk);
    compare_all("R1 reset from native state");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule